// File: doc/BRIEF.md
# I2C SCL Multi-Speed Clock Generator

This block produces the serial clock of an I2C controller from a fast system clock. It drives SCL low through an open-drain pull-down output and releases it for the high part of each period. The low and high durations come from one of three programmable count pairs (standard, fast, high speed). A speed code in a control register picks the pair. Fast-plus operation uses the fast pair loaded with shorter counts. When the core is built without high-speed support, a high-speed request runs on the fast pair.

The high part of the period is counted only once the sensed SCL line reads high. A target that holds SCL low therefore stretches the clock. Three single-cycle strobes go to the bit engine: SCL began its counted high part, SCL was pulled low, and SDA may now change. The last one comes a programmable number of cycles after the falling edge. The count registers accept writes only while the generator is disabled. Requested counts that are too short are raised to a floor.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `scl_drive_low` and all three strobes are 0. The reset configuration is speed code 2 with the fast pair at 60 high and 130 low cycles, the standard pair at 400/470, the high-speed pair at 6/16 and an SDA hold of 0.
- R2: Register addresses are: 0 control (speed code in bits 1:0), 1 standard high, 2 standard low, 3 fast high, 4 fast low, 5 high-speed high, 6 high-speed low, 7 SDA hold. Speed code 1 selects the standard pair, 2 the fast pair and 3 the high-speed pair. Code 0 behaves as standard.
- R3: When HS_SUPPORTED is 0, speed code 3 uses the fast pair, and writes to addresses 5 and 6 have no effect.
- R4: With no stretching, each period holds `scl_drive_low` at 1 for exactly LO cycles and at 0 for exactly HI cycles.
- R5: If the sensed `scl_in` stays low for S cycles after the release, the released part lasts S+HI cycles.
- R6: A high count below MIN_HI (6) acts as 6. A low count below MIN_LO (8) acts as 8.
- R7: `scl_fall_tick` pulses in the first cycle of each low part. `scl_rise_tick` pulses once per period, in the cycle after the first clock edge at which `scl_in` is sampled high, which is the second released cycle when there is no stretching.
- R8: `sda_upd_tick` pulses H cycles after `scl_fall_tick`. H is the hold register, or 1 when the hold register is 0.
- R9: Register writes made while `gen_en` is 1 are discarded and do not change any later period.
- R10: When `gen_en` is 0, SCL is released from the next cycle on and no strobe fires.
- R11: In the cycle after `gen_en` rises, the generator begins a low part, asserting both `scl_drive_low` and `scl_fall_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| gen_en | input | 1 | Run the clock generator |
| scl_in | input | 1 | Sensed SCL line level, already synchronized |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| scl_rise_tick | output | 1 | Strobe: counted high part begins |
| scl_fall_tick | output | 1 | Strobe: SCL pulled low |
| sda_upd_tick | output | 1 | Strobe: SDA may change |

## Verification
The bench uses two instances with 12-bit counts: u0 built with high-speed support and u1 built without it. Both share the write port and enable, so a single speed-code-3 configuration shows the high-speed pair on u0 and the fast fallback on u1 side by side. Small programmed counts, around 10 to 20 cycles, make it cheap to measure many periods exactly, to hit the clamp floor and to insert a known stretch. The reset-default fast period is also measured once in full.

// File: rtl/scl_gen_pkg.sv
// Shared constants for the SCL clock generator: speed codes, register
// addresses and the phase encoding of the waveform state machine.
package scl_gen_pkg;

    localparam logic [1:0] SPD_STD  = 2'd1;
    localparam logic [1:0] SPD_FAST = 2'd2;
    localparam logic [1:0] SPD_HS   = 2'd3;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_SS_HI = 3'd1;
    localparam logic [2:0] A_SS_LO = 3'd2;
    localparam logic [2:0] A_FS_HI = 3'd3;
    localparam logic [2:0] A_FS_LO = 3'd4;
    localparam logic [2:0] A_HS_HI = 3'd5;
    localparam logic [2:0] A_HS_LO = 3'd6;
    localparam logic [2:0] A_HOLD  = 3'd7;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

endpackage

// File: rtl/scl_cfg_regs.sv
// Timing register bank. It holds the speed code, the count pairs and the
// SDA hold count, and presents the clamped high, low and hold counts of the
// selected mode. Assumes gen_en marks the running state. Writes are accepted
// only while gen_en is low.
module scl_cfg_regs
    import scl_gen_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter bit HS_SUPPORTED = 1'b1,
    parameter int MIN_HI       = 6,
    parameter int MIN_LO       = 8,
    parameter int HOLD_MIN     = 1,
    parameter int SS_HI_RST    = 400,
    parameter int SS_LO_RST    = 470,
    parameter int FS_HI_RST    = 60,
    parameter int FS_LO_RST    = 130,
    parameter int HS_HI_RST    = 6,
    parameter int HS_LO_RST    = 16,
    parameter int SPEED_RST    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             gen_en,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] lo_cnt,
    output logic [CNT_W-1:0] hold_cnt
);

    localparam logic [CNT_W-1:0] HI_FLOOR = CNT_W'(MIN_HI);
    localparam logic [CNT_W-1:0] LO_FLOOR = CNT_W'(MIN_LO);
    localparam logic [CNT_W-1:0] HOLD_FLR = CNT_W'(HOLD_MIN);

    logic             wr_ok;
    logic [1:0]       speed_q;
    logic [CNT_W-1:0] ss_hi_q, ss_lo_q, fs_hi_q, fs_lo_q, hold_q;
    logic [CNT_W-1:0] hs_hi, hs_lo;
    logic [CNT_W-1:0] hi_raw, lo_raw;

    // Writes land only while the generator is stopped.
    assign wr_ok = wr_en && !gen_en;

    // Speed code, standard and fast pairs, and the hold count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q <= 2'(SPEED_RST);
            ss_hi_q <= CNT_W'(SS_HI_RST);
            ss_lo_q <= CNT_W'(SS_LO_RST);
            fs_hi_q <= CNT_W'(FS_HI_RST);
            fs_lo_q <= CNT_W'(FS_LO_RST);
            hold_q  <= '0;
        end else if (wr_ok) begin
            case (wr_addr)
                A_CTRL:  speed_q <= wr_data[1:0];
                A_SS_HI: ss_hi_q <= wr_data;
                A_SS_LO: ss_lo_q <= wr_data;
                A_FS_HI: fs_hi_q <= wr_data;
                A_FS_LO: fs_lo_q <= wr_data;
                A_HOLD:  hold_q  <= wr_data;
                default: ;
            endcase
        end
    end

    // The high-speed pair exists only when the build supports it.
    generate
        if (HS_SUPPORTED) begin : g_hs
            logic [CNT_W-1:0] hs_hi_q, hs_lo_q;

            // High-speed pair storage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hs_hi_q <= CNT_W'(HS_HI_RST);
                    hs_lo_q <= CNT_W'(HS_LO_RST);
                end else if (wr_ok && wr_addr == A_HS_HI) begin
                    hs_hi_q <= wr_data;
                end else if (wr_ok && wr_addr == A_HS_LO) begin
                    hs_lo_q <= wr_data;
                end
            end
            assign hs_hi = hs_hi_q;
            assign hs_lo = hs_lo_q;
        end else begin : g_no_hs
            assign hs_hi = fs_hi_q;
            assign hs_lo = fs_lo_q;
        end
    endgenerate

    // Pick the pair named by the speed code.
    always_comb begin
        case (speed_q)
            SPD_HS: begin
                hi_raw = hs_hi;
                lo_raw = hs_lo;
            end
            SPD_FAST: begin
                hi_raw = fs_hi_q;
                lo_raw = fs_lo_q;
            end
            default: begin
                hi_raw = ss_hi_q;
                lo_raw = ss_lo_q;
            end
        endcase
    end

    // Raise short counts to their floors. A zero hold means the minimum.
    always_comb begin
        hi_cnt   = (hi_raw < HI_FLOOR) ? HI_FLOOR : hi_raw;
        lo_cnt   = (lo_raw < LO_FLOOR) ? LO_FLOOR : lo_raw;
        hold_cnt = (hold_q == '0) ? HOLD_FLR : hold_q;
    end

endmodule

// File: rtl/scl_phase_fsm.sv
// SCL waveform state machine. It counts the low part, waits for the sensed
// line to read high, then counts the high part. The wait cycle counts toward
// the high part. Assumes hi_cnt >= 2 and lo_cnt >= 1, which the clamp in the
// register bank guarantees, and that scl_in is synchronized upstream.
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    output logic             scl_drive_low,
    output logic             rise_tick,
    output logic             fall_tick,
    output logic             fall_start
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    scl_phase_e       ph_q;
    logic [CNT_W-1:0] cnt_q;

    // A low part begins on this edge.
    assign fall_start = gen_en && ((ph_q == PH_IDLE) ||
                                   (ph_q == PH_HIGH && cnt_q == '0));

    // Phase sequencing, period counting and the edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q          <= PH_IDLE;
            cnt_q         <= '0;
            scl_drive_low <= 1'b0;
            rise_tick     <= 1'b0;
            fall_tick     <= 1'b0;
        end else begin
            rise_tick <= 1'b0;
            fall_tick <= 1'b0;
            if (!gen_en) begin
                ph_q          <= PH_IDLE;
                cnt_q         <= '0;
                scl_drive_low <= 1'b0;
            end else begin
                case (ph_q)
                    PH_IDLE: begin
                        ph_q          <= PH_LOW;
                        cnt_q         <= lo_cnt - ONE;
                        scl_drive_low <= 1'b1;
                        fall_tick     <= 1'b1;
                    end
                    PH_LOW: begin
                        if (cnt_q == '0) begin
                            ph_q          <= PH_WAIT;
                            scl_drive_low <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q - ONE;
                        end
                    end
                    PH_WAIT: begin
                        if (scl_in) begin
                            ph_q      <= PH_HIGH;
                            cnt_q     <= hi_cnt - TWO;
                            rise_tick <= 1'b1;
                        end
                    end
                    default: begin
                        if (cnt_q == '0) begin
                            ph_q          <= PH_LOW;
                            cnt_q         <= lo_cnt - ONE;
                            scl_drive_low <= 1'b1;
                            fall_tick     <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - ONE;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sda_hold_timer.sv
// SDA hold delay. It is loaded when a low part begins and pulses
// sda_upd_tick hold_cnt cycles after the fall strobe. Assumes hold_cnt >= 1.
// A new fall restarts it, and disabling cancels it.
module sda_hold_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             start,
    input  logic [CNT_W-1:0] hold_cnt,
    output logic             sda_upd_tick
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Delay count and the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q       <= 1'b0;
            cnt_q        <= '0;
            sda_upd_tick <= 1'b0;
        end else begin
            sda_upd_tick <= 1'b0;
            if (!gen_en) begin
                busy_q <= 1'b0;
            end else if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= hold_cnt - ONE;
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q       <= 1'b0;
                    sda_upd_tick <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/scl_rate_gen.sv
// Top of the SCL clock generator. It joins the register bank, the waveform
// state machine and the SDA hold timer. Assumes scl_in is the synchronized
// level of the bus wire that scl_drive_low pulls down.
module scl_rate_gen #(
    parameter int CNT_W        = 16,
    parameter bit HS_SUPPORTED = 1'b1,
    parameter int MIN_HI       = 6,
    parameter int MIN_LO       = 8,
    parameter int HOLD_MIN     = 1,
    parameter int SS_HI_RST    = 400,
    parameter int SS_LO_RST    = 470,
    parameter int FS_HI_RST    = 60,
    parameter int FS_LO_RST    = 130,
    parameter int HS_HI_RST    = 6,
    parameter int HS_LO_RST    = 16,
    parameter int SPEED_RST    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             gen_en,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             scl_rise_tick,
    output logic             scl_fall_tick,
    output logic             sda_upd_tick
);

    logic [CNT_W-1:0] hi_cnt, lo_cnt, hold_cnt;
    logic             fall_start;

    scl_cfg_regs #(
        .CNT_W(CNT_W), .HS_SUPPORTED(HS_SUPPORTED), .MIN_HI(MIN_HI),
        .MIN_LO(MIN_LO), .HOLD_MIN(HOLD_MIN), .SS_HI_RST(SS_HI_RST),
        .SS_LO_RST(SS_LO_RST), .FS_HI_RST(FS_HI_RST), .FS_LO_RST(FS_LO_RST),
        .HS_HI_RST(HS_HI_RST), .HS_LO_RST(HS_LO_RST), .SPEED_RST(SPEED_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gen_en(gen_en), .hi_cnt(hi_cnt),
        .lo_cnt(lo_cnt), .hold_cnt(hold_cnt)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .scl_in(scl_in),
        .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .scl_drive_low(scl_drive_low),
        .rise_tick(scl_rise_tick), .fall_tick(scl_fall_tick),
        .fall_start(fall_start)
    );

    sda_hold_timer #(.CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .start(fall_start),
        .hold_cnt(hold_cnt), .sda_upd_tick(sda_upd_tick)
    );

endmodule

// File: rtl/scl_rate_gen_chk.sv
// Property checker for scl_rate_gen, attached by bind. It keeps its own
// count of consecutive drive-low cycles to check the low-part floor.
module scl_rate_gen_chk #(
    parameter int MIN_LO = 8
) (
    input logic clk,
    input logic rst_n,
    input logic gen_en,
    input logic scl_in,
    input logic scl_drive_low,
    input logic scl_rise_tick,
    input logic scl_fall_tick
);

    int unsigned low_run;

    // Length of the current drive-low run.
    always_ff @(posedge clk) begin
        if (!rst_n) low_run <= 0;
        else if (scl_drive_low) low_run <= low_run + 1;
        else low_run <= 0;
    end

    p_edge_ticks_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise_tick, scl_fall_tick}));

    p_fall_marks_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> scl_fall_tick);

    p_fall_while_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_tick |-> scl_drive_low);

    p_rise_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_tick |-> (!scl_drive_low && $past(scl_in)));

    p_release_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !scl_drive_low);

    p_low_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_drive_low) && $past(gen_en)) |-> (low_run >= MIN_LO));

endmodule

bind scl_rate_gen scl_rate_gen_chk #(.MIN_LO(MIN_LO)) u_chk (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .scl_rise_tick(scl_rise_tick),
    .scl_fall_tick(scl_fall_tick)
);

// File: tb/sim_scl_rate_gen.sv
// Directed bench for scl_rate_gen. u0 supports high speed and u1 does not.
// Both share the write port and the enable.
module sim_scl_rate_gen;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          gen_en = 1'b0;
    logic          stretch = 1'b0;
    logic          drv0, rise0, fall0, sda0;
    logic          drv1, rise1, fall1, sda1;
    logic          scl0, scl1;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    assign scl0 = ~drv0 & ~stretch;
    assign scl1 = ~drv1;

    always #4 clk = ~clk;

    scl_rate_gen #(.CNT_W(CW), .HS_SUPPORTED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gen_en(gen_en), .scl_in(scl0),
        .scl_drive_low(drv0), .scl_rise_tick(rise0),
        .scl_fall_tick(fall0), .sda_upd_tick(sda0)
    );

    scl_rate_gen #(.CNT_W(CW), .HS_SUPPORTED(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gen_en(gen_en), .scl_in(scl1),
        .scl_drive_low(drv1), .scl_rise_tick(rise1),
        .scl_fall_tick(fall1), .sda_upd_tick(sda1)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic drv_of(input int w);
        return (w == 1) ? drv1 : drv0;
    endfunction

    function automatic logic fall_of(input int w);
        return (w == 1) ? fall1 : fall0;
    endfunction

    function automatic logic rise_of(input int w);
        return (w == 1) ? rise1 : rise0;
    endfunction

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_gen();
        @(negedge clk);
        gen_en = 1'b1;
    endtask

    task automatic stop_gen();
        @(negedge clk);
        gen_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Measure one full period that begins at the next fall strobe.
    task automatic measure(input int w, output int lo, output int hi, output int rise_at);
        do @(negedge clk); while (fall_of(w) !== 1'b1);
        lo = 0;
        while (drv_of(w) === 1'b1) begin lo++; @(negedge clk); end
        hi = 0; rise_at = -1;
        while (drv_of(w) === 1'b0) begin
            if (rise_of(w) === 1'b1) rise_at = hi;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic run_and_check(input int w, input string req, input int elo, input int ehi);
        int lo, hi, ra;
        start_gen();
        measure(w, lo, hi, ra);
        chk({req, " low"}, lo, elo);
        chk({req, " high"}, hi, ehi);
        stop_gen();
    endtask

    task automatic t_reset_and_default();
        int lo, hi, ra;
        chk("R1 drive after reset", int'(drv0), 0);
        chk("R1 ticks after reset", int'(rise0) + int'(fall0) + int'(sda0), 0);
        start_gen();
        @(negedge clk);
        chk("R11 fall tick on start", int'(fall0), 1);
        chk("R11 drive on start", int'(drv0), 1);
        measure(0, lo, hi, ra);
        chk("R1 default fast low", lo, 130);
        chk("R1 default fast high", hi, 60);
        chk("R4 R7 rise tick position", ra, 1);
        stop_gen();
    endtask

    task automatic t_speed_select();
        wr(3'd1, 20); wr(3'd2, 30);
        wr(3'd3, 11); wr(3'd4, 17);
        wr(3'd5, 9);  wr(3'd6, 12);
        wr(3'd0, 1);
        run_and_check(0, "R2 R4 standard", 30, 20);
        wr(3'd0, 2);
        run_and_check(0, "R2 R4 fast", 17, 11);
        wr(3'd0, 3);
        run_and_check(0, "R2 high speed", 12, 9);
        wr(3'd0, 0);
        run_and_check(0, "R2 code 0 standard", 30, 20);
    endtask

    task automatic t_fallback();
        int lo, hi, ra;
        wr(3'd0, 3);
        start_gen();
        measure(0, lo, hi, ra);
        chk("R3 hs-capable low", lo, 12);
        measure(1, lo, hi, ra);
        chk("R3 fallback low", lo, 17);
        chk("R3 fallback high", hi, 11);
        stop_gen();
    endtask

    task automatic t_clamp();
        wr(3'd0, 2);
        wr(3'd3, 2); wr(3'd4, 3);
        run_and_check(0, "R6 clamp small", 8, 6);
        wr(3'd3, 0); wr(3'd4, 0);
        run_and_check(0, "R6 clamp zero", 8, 6);
        wr(3'd3, 11); wr(3'd4, 17);
    endtask

    task automatic t_stretch();
        int lo, hi, ra;
        start_gen();
        do @(negedge clk); while (fall0 !== 1'b1);
        lo = 0;
        while (drv0 === 1'b1) begin lo++; @(negedge clk); end
        hi = 0; ra = -1;
        while (drv0 === 1'b0) begin
            if (hi == 0) stretch = 1'b1;
            if (hi == 5) stretch = 1'b0;
            if (rise0 === 1'b1) ra = hi;
            hi++;
            @(negedge clk);
        end
        chk("R5 stretched high", hi, 16);
        chk("R5 R7 rise after stretch", ra, 6);
        stop_gen();
    endtask

    task automatic hold_distance(input string req, input int exp);
        int k;
        start_gen();
        do @(negedge clk); while (fall0 !== 1'b1);
        k = 0;
        do begin @(negedge clk); k++; end while (sda0 !== 1'b1 && k < 100);
        chk(req, k, exp);
        stop_gen();
    endtask

    task automatic t_sda_hold();
        wr(3'd7, 5);
        hold_distance("R8 hold 5", 5);
        wr(3'd7, 0);
        hold_distance("R8 hold 0 minimum", 1);
    endtask

    task automatic t_ignore_writes();
        int lo, hi, ra;
        start_gen();
        wr(3'd3, 40);
        wr(3'd0, 1);
        measure(0, lo, hi, ra);
        chk("R9 write while enabled low", lo, 17);
        chk("R9 write while enabled high", hi, 11);
        stop_gen();
        run_and_check(0, "R9 after restart", 17, 11);
    endtask

    task automatic t_disable();
        int ticks;
        start_gen();
        repeat (3) @(negedge clk);
        gen_en = 1'b0;
        @(negedge clk);
        chk("R10 release after disable", int'(drv0), 0);
        ticks = 0;
        repeat (30) begin
            @(negedge clk);
            ticks += int'(rise0) + int'(fall0) + int'(sda0) + int'(drv0);
        end
        chk("R10 quiet while disabled", ticks, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_default();
        t_speed_select();
        t_fallback();
        t_clamp();
        t_stretch();
        t_sda_hold();
        t_ignore_writes();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule